// File: doc/BRIEF.md
# Serial SAR Converter Capture Controller

This block sits on the host side of a three-wire link (chip select, serial clock, serial data) to a micro-power successive-approximation converter. It generates the select and clock waveforms from the system clock, shifts in the returned bits, and presents each finished conversion as a parallel word with a one-cycle strobe. The converter takes its sample, and starts converting, at the moment select falls. Each frame therefore returns the sample from its own select edge, with no pipeline delay.

A frame starts from a single-cycle request or continuously while free-run is held. The resolution select sets the frame length: 16 clocks for 12 bits, 12 clocks for 10 bits and 10 clocks for 8 bits. The bits that arrive before the data field are filler and are dropped. The serial clock half-period is programmable in system clocks. After each frame, a programmable quiet time must pass before select may fall again. The converter powers itself down after every frame, so the controller issues no power commands.

Top module: `sar_capture_ctrl`

## Requirements
- R1: While reset (synchronous, active low) is applied and afterwards until a request arrives, `csN` and `sclk` are high and `sampleValid` is low; reset in the middle of a frame aborts it and discards any held request.
- R2: `resSel` encodes the resolution as 0 = 12 bits, 1 = 10 bits, 2 or 3 = 8 bits; `sample` carries the last captured 12, 10 or 8 bits as a natural binary value with the oldest bit as MSB, zero-extended to 12 bits.
- R3: Each frame has exactly 16, 12 or 10 `sclk` falling edges for resolutions 12, 10 and 8.
- R4: While `csN` is low, every `sclk` high phase and low phase lasts exactly `divHalf` clocks (0 acts as 1); `sclk` stays high for `divHalf` clocks after `csN` falls and after the last rising edge, so `csN` stays low for `divHalf*(2N+1)` clocks.
- R5: Between consecutive frames under a standing request, `csN` stays high for exactly `quietCycles+2` clocks.
- R6: `sampleValid` is high for one clock, in the same cycle that `csN` returns high, and at no other time.
- R7: A request seen while idle pulls `csN` low on the next clock edge; a request during a frame or quiet gap is held and starts exactly one further frame after the gap; with no request, no frame starts.
- R8: Filler bits at the start of a frame do not affect `sample`, whatever their value.
- R9: `sclk` is high in every cycle in which `csN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| startReq | input | 1 | Single-cycle conversion request |
| freeRun | input | 1 | Repeat frames while high |
| resSel | input | 2 | Resolution select (0:12, 1:10, 2/3:8 bits) |
| divHalf | input | DIV_W | Serial clock half-period in system clocks |
| quietCycles | input | QUIET_W | Extra idle clocks after each frame |
| sdataIn | input | 1 | Serial data from the converter |
| csN | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Serial clock to the converter |
| sample | output | 12 | Captured conversion result |
| sampleValid | output | 1 | One-cycle strobe marking a new result |

## Verification
The assertions assume that `resSel`, `divHalf` and `quietCycles` are changed only while no frame is running. They also assume that `sdataIn` changes only after a serial clock falling edge, so it is stable when the rising edge samples it. The bench changes its settings only after `csN` has stayed high well past the quiet time. Its converter model updates the data line only on falling `sclk` edges, and it drives filler bits as ones so that any leak of filler into the result shows up.

// File: rtl/sar_cap_pkg.sv
package sar_cap_pkg;
  localparam int SHIFT_W = 16;
  localparam int RES_W   = 12;
  localparam int LEN_W   = $clog2(SHIFT_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_LOW, ST_HIGH, ST_QUIET
  } ctrlState_t;

  typedef struct packed {
    logic clear;
    logic shift;
    logic load;
  } dpStrobe_t;

  function automatic logic [LEN_W-1:0] frameLenOf(input logic [1:0] sel);
    case (sel)
      2'd0:    return LEN_W'(16);
      2'd1:    return LEN_W'(12);
      default: return LEN_W'(10);
    endcase
  endfunction
endpackage

// File: rtl/sar_cap_ctrl.sv
module sar_cap_ctrl
  import sar_cap_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int QUIET_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               freeRun,
  input  logic [1:0]         resSel,
  input  logic [DIV_W-1:0]   divHalf,
  input  logic [QUIET_W-1:0] quietCycles,
  output logic               csNQ,
  output logic               sclkQ,
  output logic [1:0]         resLatch,
  output dpStrobe_t          strobe
);
  ctrlState_t         state;
  logic [DIV_W-1:0]   phaseCnt;
  logic [DIV_W-1:0]   divLatch;
  logic [QUIET_W-1:0] quietCnt;
  logic [LEN_W-1:0]   bitCnt;
  logic [LEN_W-1:0]   frameLen;
  logic               pend;
  logic               go;
  logic [DIV_W-1:0]   divEff;
  logic               phaseEnd;

  assign go       = pend | startReq | freeRun;
  assign divEff   = (divHalf == '0) ? DIV_W'(1) : divHalf;
  assign phaseEnd = (phaseCnt == '0);

  always_comb begin
    strobe.clear = (state == ST_IDLE) && go;
    strobe.shift = (state == ST_LOW) && phaseEnd;
    strobe.load  = (state == ST_HIGH) && phaseEnd && (bitCnt == frameLen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      csNQ     <= 1'b1;
      sclkQ    <= 1'b1;
      phaseCnt <= '0;
      divLatch <= DIV_W'(1);
      quietCnt <= '0;
      bitCnt   <= '0;
      frameLen <= LEN_W'(16);
      resLatch <= 2'd0;
      pend     <= 1'b0;
    end else begin
      pend <= (state != ST_IDLE) && (pend || startReq);
      unique case (state)
        ST_IDLE: begin
          if (go) begin
            csNQ     <= 1'b0;
            phaseCnt <= divEff - DIV_W'(1);
            divLatch <= divEff;
            bitCnt   <= '0;
            frameLen <= frameLenOf(resSel);
            resLatch <= resSel;
            state    <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (phaseEnd) begin
            sclkQ    <= 1'b0;
            phaseCnt <= divLatch - DIV_W'(1);
            state    <= ST_LOW;
          end else begin
            phaseCnt <= phaseCnt - DIV_W'(1);
          end
        end
        ST_LOW: begin
          if (phaseEnd) begin
            sclkQ    <= 1'b1;
            bitCnt   <= bitCnt + LEN_W'(1);
            phaseCnt <= divLatch - DIV_W'(1);
            state    <= ST_HIGH;
          end else begin
            phaseCnt <= phaseCnt - DIV_W'(1);
          end
        end
        ST_HIGH: begin
          if (phaseEnd) begin
            if (bitCnt == frameLen) begin
              csNQ     <= 1'b1;
              quietCnt <= quietCycles;
              state    <= ST_QUIET;
            end else begin
              sclkQ    <= 1'b0;
              phaseCnt <= divLatch - DIV_W'(1);
              state    <= ST_LOW;
            end
          end else begin
            phaseCnt <= phaseCnt - DIV_W'(1);
          end
        end
        ST_QUIET: begin
          if (quietCnt == '0) state <= ST_IDLE;
          else                quietCnt <= quietCnt - QUIET_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: the serial clock idles high whenever select is released
  a_r9_sclk_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    csNQ |-> sclkQ);
  // R3: the bit counter never runs past the frame length
  a_r3_bit_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= frameLen);
  // R5: select stays high for at least two cycles after each frame
  a_r5_min_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csNQ) |=> csNQ);
  // R4: the clock is high when select falls
  a_r4_lead_high: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csNQ) |-> sclkQ);
endmodule

// File: rtl/sar_cap_dpath.sv
module sar_cap_dpath
  import sar_cap_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [1:0]       resLatch,
  input  logic             sdataIn,
  output logic [RES_W-1:0] sample,
  output logic             sampleValid
);
  logic [SHIFT_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg    <= '0;
      sample      <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobe.load;
      if (strobe.clear)      shiftReg <= '0;
      else if (strobe.shift) shiftReg <= {shiftReg[SHIFT_W-2:0], sdataIn};
      if (strobe.load) begin
        unique case (resLatch)
          2'd0:    sample <= shiftReg[11:0];
          2'd1:    sample <= {2'b00, shiftReg[9:0]};
          default: sample <= {4'h0, shiftReg[7:0]};
        endcase
      end
    end
  end

  // R6: the result strobe never lasts more than one cycle
  a_r6_single_valid: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);
  // R8: a capture edge and the result load never coincide
  a_r8_no_shift_on_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |-> !strobe.load);
endmodule

// File: rtl/sar_capture_ctrl.sv
module sar_capture_ctrl
  import sar_cap_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int QUIET_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               freeRun,
  input  logic [1:0]         resSel,
  input  logic [DIV_W-1:0]   divHalf,
  input  logic [QUIET_W-1:0] quietCycles,
  input  logic               sdataIn,
  output logic               csN,
  output logic               sclk,
  output logic [11:0]        sample,
  output logic               sampleValid
);
  dpStrobe_t  strobe;
  logic [1:0] resLatch;

  sar_cap_ctrl #(.DIV_W(DIV_W), .QUIET_W(QUIET_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .freeRun(freeRun),
    .resSel(resSel), .divHalf(divHalf), .quietCycles(quietCycles),
    .csNQ(csN), .sclkQ(sclk), .resLatch(resLatch), .strobe(strobe)
  );

  sar_cap_dpath dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .resLatch(resLatch),
    .sdataIn(sdataIn), .sample(sample), .sampleValid(sampleValid)
  );

  // R6: the result strobe coincides with select returning high
  a_r6_valid_with_cs: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (csN && !$past(csN)));
endmodule

// File: tb/sar_capture_ctrl_tb_top.sv
module sar_capture_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic       freeRun = 1'b0;
  logic [1:0] resSel = 2'd0;
  logic [7:0] divHalf = 8'd1;
  logic [7:0] quietCycles = 8'd0;
  logic       sdataIn = 1'b1;
  logic       csN, sclk, sampleValid;
  logic [11:0] sample;

  int checks = 0, fails = 0;
  int cfgD = 1, cfgN = 16, cfgRes = 12, cfgQ = 0;
  bit gapCheckOn = 0;
  int frameIdx = 0, doneFrames = 0, bitIdx = 0;
  logic [11:0] mExp = '0;
  int cycles = 0;

  always #10 clk = ~clk;

  sar_capture_ctrl dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .freeRun(freeRun),
    .resSel(resSel), .divHalf(divHalf), .quietCycles(quietCycles),
    .sdataIn(sdataIn), .csN(csN), .sclk(sclk), .sample(sample),
    .sampleValid(sampleValid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lenOf(input logic [1:0] s);
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 12 : 10;
  endfunction
  function automatic int resOf(input logic [1:0] s);
    return (s == 2'd0) ? 12 : (s == 2'd1) ? 10 : 8;
  endfunction

  // converter stand-in: filler bits are ones, then the code MSB first
  always @(negedge csN) begin
    if (rstN) begin
      mExp = 12'(((frameIdx * 37) + 11) & ((1 << cfgRes) - 1));
      frameIdx++;
      bitIdx = 0;
    end
  end
  always @(negedge sclk) begin
    if (!csN) begin
      if (bitIdx < cfgN - cfgRes) sdataIn = 1'b1;
      else sdataIn = mExp[cfgN - 1 - bitIdx];
      bitIdx++;
    end
  end

  // port monitor
  logic prevCs = 1'b1, prevSclk = 1'b1;
  int csLow = 0, runLen = 0, fallCnt = 0, gapCnt = 0;
  always @(negedge clk) begin
    cycles++;
    if (!rstN) begin
      prevCs = 1'b1; prevSclk = 1'b1; csLow = 0; runLen = 0; fallCnt = 0;
      gapCnt = 0;
    end else begin
      if (csN && !sclk) chk(0, "R9", "sclk low while csN high", 0, 1);
      if (sampleValid && !(csN && !prevCs))
        chk(0, "R6", "stray sampleValid", 1, 0);
      if (prevCs && !csN) begin
        if (gapCheckOn) chk(gapCnt == cfgQ + 2, "R5", "quiet gap", gapCnt, cfgQ + 2);
        csLow = 1; runLen = 1; fallCnt = 0;
      end else if (!csN) begin
        csLow++;
        if (sclk != prevSclk) begin
          chk(runLen == cfgD, "R4", "sclk phase width", runLen, cfgD);
          runLen = 1;
          if (!sclk) fallCnt++;
        end else runLen++;
      end else if (!prevCs && csN) begin
        chk(sampleValid == 1'b1, "R6", "valid at csN rise", int'(sampleValid), 1);
        chk(sample == mExp, "R2/R8", "sample value", int'(sample), int'(mExp));
        chk(fallCnt == cfgN, "R3", "falling edges", fallCnt, cfgN);
        chk(csLow == cfgD * (2 * cfgN + 1), "R4", "csN low width", csLow,
            cfgD * (2 * cfgN + 1));
        chk(runLen == cfgD, "R4", "trailing high", runLen, cfgD);
        gapCnt = 1;
        doneFrames++;
      end else gapCnt++;
      prevCs = csN; prevSclk = sclk;
    end
  end

  task automatic waitIdle();
    int hi = 0;
    while (hi < cfgQ + 8) begin
      @(negedge clk);
      hi = csN ? hi + 1 : 0;
    end
  endtask

  task automatic runCfg(input logic [1:0] s, input int d, input int q, input int n);
    int base, after;
    resSel = s; divHalf = 8'(d); quietCycles = 8'(q);
    cfgD = (d == 0) ? 1 : d; cfgQ = q; cfgN = lenOf(s); cfgRes = resOf(s);
    base = doneFrames;
    @(negedge clk);
    freeRun = 1'b1;
    wait (csN == 1'b0);
    repeat (2) @(negedge clk);
    gapCheckOn = 1;
    while (frameIdx - base < n) @(negedge clk);
    freeRun = 1'b0;
    waitIdle();
    gapCheckOn = 0;
    after = frameIdx;
    repeat (100) @(negedge clk);
    chk(frameIdx == after, "R7", "no frame without request", frameIdx, after);
  endtask

  initial begin : watchdog
    while (cycles < 150000) @(negedge clk);
    chk(0, "watchdog", "run did not finish", cycles, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(csN == 1'b1, "R1", "csN in reset", int'(csN), 1);
    chk(sclk == 1'b1, "R1", "sclk in reset", int'(sclk), 1);
    chk(sampleValid == 1'b0, "R1", "valid in reset", int'(sampleValid), 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    chk(csN == 1'b1 && frameIdx == 0, "R1", "idle without request", int'(csN), 1);

    runCfg(2'd2, 1, 0, 256);   // all 8-bit codes
    runCfg(2'd1, 2, 3, 100);
    runCfg(2'd0, 3, 5, 100);
    runCfg(2'd3, 0, 1, 20);    // encoding 3 and divider 0

    // R7: start from idle, then held requests during frame and gap
    resSel = 2'd1; divHalf = 8'd2; quietCycles = 8'd4;
    cfgD = 2; cfgQ = 4; cfgN = 12; cfgRes = 10;
    base = frameIdx;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(csN == 1'b0, "R7", "csN one cycle after request", int'(csN), 0);
    repeat (2) @(negedge clk);
    gapCheckOn = 1;
    repeat (5) @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    while (frameIdx - base < 2) @(negedge clk);
    wait (csN == 1'b1);
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitIdle();
    repeat (200) @(negedge clk);
    chk(frameIdx - base == 3, "R7", "held requests give one frame each",
        frameIdx - base, 3);
    gapCheckOn = 0;

    // R1: reset in the middle of a frame with a request held
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (6) @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    chk(csN == 1'b1, "R1", "csN after mid-frame reset", int'(csN), 1);
    chk(sclk == 1'b1, "R1", "sclk after mid-frame reset", int'(sclk), 1);
    chk(sampleValid == 1'b0, "R1", "valid after mid-frame reset", int'(sampleValid), 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    base = frameIdx;
    repeat (100) @(negedge clk);
    chk(frameIdx == base && csN == 1'b1, "R1", "held request dropped by reset",
        frameIdx, base);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule